// File: doc/BRIEF.md
# Register-Mask Multi-Store Sequencer

This block writes a chosen subset of a bank of sixteen 32-bit registers out to memory through a 16-bit write port. A 16-bit selection mask picks the registers. The caller pulses `start_i` with the mask, a direction mode, a transfer size and a base address. The block then issues one bus beat per half-word until every selected register has been stored. Each beat holds its address, data and request until the memory side answers with `wr_ready_i`.

There are two directions. In ascending mode, mask bit n selects register n. Stores go upward from the base address. In predecrement mode, the mask is still consumed from bit 0 upward, but bit n now selects register 15−n. The address steps downward, and it is reduced before every store. When a predecrement run completes, the lowest address written is presented on `wb_addr_o` for the caller to write back into the base register. Mask bits that are clear cost no bus beat: a priority encoder jumps straight to the next set bit.

Top module: `regmask_store_seq`

## Requirements
- R1: In ascending mode, mask bit n (consumed from bit 0 upward) stores register n, so lower-numbered registers go out first.
- R2: In predecrement mode, mask bit n (still consumed from bit 0 upward) stores register 15−n, so register 15 is the first candidate and register 0 the last.
- R3: A clear mask bit produces no bus beat. A run issues exactly popcount(mask) beats in word size and twice that in longword size.
- R4: A run ends once the remaining mask is zero. With an all-zero mask, `done_o` pulses in the second cycle after the start cycle and no beat is issued.
- R5: In ascending mode, each beat writes to the current address, and the address then rises by 2.
- R6: In predecrement mode, the address is reduced by 2 before each beat. The first beat therefore goes to base−2, not to base.
- R7: In ascending longword size, bits 31:16 of a register are stored at address a and bits 15:0 at a+2.
- R8: In predecrement longword size, bits 15:0 are stored first at the higher address a−2, then bits 31:16 at a−4.
- R9: On completion of a predecrement run, `wb_valid_o` pulses together with `done_o`, and `wb_addr_o` equals base − 2×(beats issued). `wb_valid_o` stays low for ascending runs.
- R10: In word size, only bits 15:0 of each selected register are stored.
- R11: While `wr_req_o` is high and `wr_ready_i` is low, the request, address and data hold steady into the next cycle.
- R12: `busy_o` is high from the cycle after `start_i` until the cycle in which the one-cycle `done_o` pulse appears. A `start_i` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run; latches mask, mode, size and base |
| mask_i | input | 16 | Register selection mask |
| predec_i | input | 1 | 1 = predecrement mode, 0 = ascending mode |
| long_i | input | 1 | 1 = longword size, 0 = word size |
| base_i | input | 32 | Starting address (raw base register value) |
| regs_i | input | 512 | Register bank, register k at bits 32k+31:32k |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Byte address of the current beat |
| wr_data_o | output | 16 | Data of the current beat |
| wr_ready_i | input | 1 | Memory accepts the beat at this edge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback address valid (predecrement only) |
| wb_addr_o | output | 32 | Final address for base-register writeback |

## Verification
The bench sets the two directions and the two sizes against each other. A design that walked registers upward in predecrement mode, or that forgot to flip the half order, would put the wrong half-word at a given address, and the comparison beat by beat would show it. The bench also drives sparse masks with long runs of zeros, a full mask, masks with only bit 0 or only bit 15 set, and an all-zero mask. These expose an off-by-one in the skip shift, a missing decrement of the first predecrement address, and a writeback value that is two too high. Random `wr_ready_i` stalls and a spurious mid-run `start_i` catch beats that change while stalled, and runs that restart.

// File: rtl/rms_pkg.sv
package rms_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PICK = 2'd1,
      ST_BEAT = 2'd2
   } rms_state_e;
endpackage

// File: rtl/rms_lsb_find.sv
module rms_lsb_find #(
   parameter int N = 16
) (
   input  logic [N-1:0]         vec_i,
   output logic [$clog2(N)-1:0] idx_o
);
   localparam int IW = $clog2(N);

   logic [N-1:0] lowest_oh;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_oh
         if (gi == 0) begin : g_first
            assign lowest_oh[gi] = vec_i[gi];
         end else begin : g_rest
            assign lowest_oh[gi] = vec_i[gi] & ~(|vec_i[gi-1:0]);
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int k = 0; k < N; k++) begin
         if (lowest_oh[k]) idx_o = idx_o | IW'(k);
      end
   end
endmodule

// File: rtl/rms_addr_step.sv
module rms_addr_step #(
   parameter int AW   = 32,
   parameter int STEP = 2
) (
   input  logic [AW-1:0] addr_i,
   input  logic          down_i,
   output logic [AW-1:0] addr_o
);
   always_comb begin
      if (down_i) addr_o = addr_i - AW'(STEP);
      else        addr_o = addr_i + AW'(STEP);
   end
endmodule

// File: rtl/rms_half_pick.sv
module rms_half_pick #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]   word_i,
   input  logic            hi_i,
   output logic [DW/2-1:0] half_o
);
   assign half_o = hi_i ? word_i[DW-1:DW/2] : word_i[DW/2-1:0];
endmodule

// File: rtl/regmask_store_seq.sv
module regmask_store_seq
   import rms_pkg::*;
#(
   parameter int NREG = 16,
   parameter int DW   = 32,
   parameter int AW   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [NREG-1:0]      mask_i,
   input  logic                 predec_i,
   input  logic                 long_i,
   input  logic [AW-1:0]        base_i,
   input  logic [NREG*DW-1:0]   regs_i,
   output logic                 wr_req_o,
   output logic [AW-1:0]        wr_addr_o,
   output logic [DW/2-1:0]      wr_data_o,
   input  logic                 wr_ready_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 wb_valid_o,
   output logic [AW-1:0]        wb_addr_o
);
   localparam int HW    = DW / 2;
   localparam int IW    = $clog2(NREG);
   localparam int PW    = IW + 1;
   localparam int BYTES = HW / 8;

   generate
      if (HW % 8 != 0) begin : g_bad_width
         $error("regmask_store_seq: half width must be a whole number of bytes");
      end
      if ((1 << IW) != NREG) begin : g_bad_count
         $error("regmask_store_seq: NREG must be a power of two");
      end
   endgenerate

   rms_state_e       state_q;
   logic [NREG-1:0]  mask_q;
   logic [PW-1:0]    pos_q;
   logic             predec_q, long_q, second_q, done_q;
   logic [AW-1:0]    addr_q, wa_q;
   logic [DW-1:0]    val_q;

   logic [IW-1:0]    low_idx;
   logic [PW-1:0]    pos_now;
   logic [IW-1:0]    ridx;
   logic [AW-1:0]    wa_next, addr_dec;
   logic             hi_sel;
   logic [NREG-1:0]  mask_shift;

   rms_lsb_find #(.N(NREG)) u_find (
      .vec_i (mask_q),
      .idx_o (low_idx)
   );

   rms_addr_step #(.AW(AW), .STEP(BYTES)) u_step (
      .addr_i (wa_q),
      .down_i (predec_q),
      .addr_o (wa_next)
   );

   rms_addr_step #(.AW(AW), .STEP(BYTES)) u_pre (
      .addr_i (addr_q),
      .down_i (1'b1),
      .addr_o (addr_dec)
   );

   // Half order: ascending long is high then low; predecrement is low then high.
   assign hi_sel = second_q ? predec_q : (long_q & ~predec_q);

   rms_half_pick #(.DW(DW)) u_half (
      .word_i (val_q),
      .hi_i   (hi_sel),
      .half_o (wr_data_o)
   );

   assign pos_now    = pos_q + PW'(low_idx);
   assign ridx       = predec_q ? (IW'(NREG - 1) - pos_now[IW-1:0]) : pos_now[IW-1:0];
   assign mask_shift = (mask_q >> low_idx) >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mask_q   <= '0;
         pos_q    <= '0;
         predec_q <= 1'b0;
         long_q   <= 1'b0;
         second_q <= 1'b0;
         done_q   <= 1'b0;
         addr_q   <= '0;
         wa_q     <= '0;
         val_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mask_q   <= mask_i;
                  predec_q <= predec_i;
                  long_q   <= long_i;
                  addr_q   <= base_i;
                  pos_q    <= '0;
                  state_q  <= ST_PICK;
               end
            end
            ST_PICK: begin
               if (mask_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  val_q    <= regs_i[ridx*DW +: DW];
                  mask_q   <= mask_shift;
                  pos_q    <= pos_now + PW'(1);
                  wa_q     <= predec_q ? addr_dec : addr_q;
                  second_q <= 1'b0;
                  state_q  <= ST_BEAT;
               end
            end
            ST_BEAT: begin
               if (wr_ready_i) begin
                  if (long_q && !second_q) begin
                     second_q <= 1'b1;
                     wa_q     <= wa_next;
                  end else begin
                     addr_q  <= predec_q ? wa_q : wa_next;
                     state_q <= ST_PICK;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_req_o   = (state_q == ST_BEAT);
   assign wr_addr_o  = wa_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign wb_valid_o = done_q & predec_q;
   assign wb_addr_o  = addr_q;

   // R11: a stalled beat keeps request, address and data.
   a_r11_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && !wr_ready_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

   // R12: done is a single-cycle pulse, and busy has fallen when it shows.
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r12_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R4: an exhausted mask ends the run at the next edge.
   a_r4_empty_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PICK && mask_q == '0) |=> (done_o && !wr_req_o));

   // R9: writeback valid only with done, and only for predecrement runs.
   a_r9_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |-> (done_o && predec_q));

   // R3: no beat outside a run.
   a_r3_no_idle_beat: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_req_o);

   // R6: predecrement beats never reach the latched address upward.
   a_r6_predec_below: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req_o && predec_q && !second_q) |-> (wa_q != addr_q));
endmodule

// File: tb/regmask_store_seq_test.sv
module regmask_store_seq_test;
   localparam int NREG = 16;
   localparam int DW   = 32;
   localparam int AW   = 32;
   localparam int HW   = DW / 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [NREG-1:0]   mask_i = '0;
   logic              predec_i = 1'b0;
   logic              long_i = 1'b0;
   logic [AW-1:0]     base_i = '0;
   logic [NREG*DW-1:0] regs_i = '0;
   logic              wr_req_o;
   logic [AW-1:0]     wr_addr_o;
   logic [HW-1:0]     wr_data_o;
   logic              wr_ready_i = 1'b0;
   logic              busy_o, done_o, wb_valid_o;
   logic [AW-1:0]     wb_addr_o;

   regmask_store_seq #(.NREG(NREG), .DW(DW), .AW(AW)) uut (
      .clk, .rst_n, .start_i, .mask_i, .predec_i, .long_i, .base_i, .regs_i,
      .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ready_i,
      .busy_o, .done_o, .wb_valid_o, .wb_addr_o
   );

   always #5 clk = ~clk;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   int unsigned cyc      = 0;
   bit          finished = 1'b0;

   logic [DW-1:0] reg_val [NREG];
   logic [AW-1:0] exp_addr [2*NREG];
   logic [HW-1:0] exp_data [2*NREG];
   int            exp_n;
   logic [AW-1:0] exp_final;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      wait (cyc >= 150000);
      check(1'b0, "WATCHDOG", "run hung", AW'(cyc), '0);
      summary();
   end

   // Expected beat list from R1, R2, R5-R8, R10.
   task automatic build_model(input logic [NREG-1:0] m, input bit pd, input bit lg,
                              input logic [AW-1:0] base);
      logic [AW-1:0] a;
      logic [DW-1:0] v;
      a = base;
      exp_n = 0;
      for (int i = 0; i < NREG; i++) begin
         if (m[i]) begin
            v = reg_val[pd ? NREG - 1 - i : i];
            if (!pd) begin
               if (lg) begin
                  exp_addr[exp_n] = a; exp_data[exp_n] = v[DW-1:HW]; exp_n++; a = a + 2;
               end
               exp_addr[exp_n] = a; exp_data[exp_n] = v[HW-1:0]; exp_n++; a = a + 2;
            end else begin
               a = a - 2; exp_addr[exp_n] = a; exp_data[exp_n] = v[HW-1:0]; exp_n++;
               if (lg) begin
                  a = a - 2; exp_addr[exp_n] = a; exp_data[exp_n] = v[DW-1:HW]; exp_n++;
               end
            end
         end
      end
      exp_final = a;
   endtask

   task automatic load_regs();
      for (int k = 0; k < NREG; k++) begin
         reg_val[k] = $urandom;
         regs_i[k*DW +: DW] = reg_val[k];
      end
   endtask

   // ready_mode: 0 always ready, 1 random stalls.
   task automatic run_op(input logic [NREG-1:0] m, input bit pd, input bit lg,
                         input logic [AW-1:0] base, input int ready_mode, input bit poke);
      string tag;
      int nw, waited;
      bit stalled, busy_ok;
      logic [AW-1:0] st_addr;
      logic [HW-1:0] st_data;
      build_model(m, pd, lg, base);
      tag = pd ? (lg ? "R2,R8" : "R2,R6,R10") : (lg ? "R1,R7" : "R1,R5,R10");
      @(negedge clk);
      mask_i = m; predec_i = pd; long_i = lg; base_i = base; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      nw = 0; waited = 0; stalled = 1'b0; busy_ok = 1'b1;
      forever begin
         @(negedge clk);
         waited++;
         if (poke && waited == 3) begin
            mask_i = ~m; predec_i = ~pd; base_i = base ^ 32'h100; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         wr_ready_i = (ready_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
         #1;
         if (stalled && wr_req_o) begin
            check(wr_addr_o == st_addr && wr_data_o == st_data, "R11",
                  "stalled beat changed", wr_addr_o, st_addr);
         end
         stalled = 1'b0;
         if (done_o) break;
         if (!busy_o) busy_ok = 1'b0;
         if (wr_req_o) begin
            if (wr_ready_i) begin
               if (nw < exp_n) begin
                  check(wr_addr_o == exp_addr[nw], tag, "beat address", wr_addr_o, exp_addr[nw]);
                  check(wr_data_o == exp_data[nw], tag, "beat data",
                        AW'(wr_data_o), AW'(exp_data[nw]));
               end else begin
                  check(1'b0, "R3", "extra beat", AW'(nw), AW'(exp_n));
               end
               nw++;
            end else begin
               stalled = 1'b1; st_addr = wr_addr_o; st_data = wr_data_o;
            end
         end
         if (waited > 400) begin
            check(1'b0, "R4", "run never completed", AW'(waited), '0);
            break;
         end
      end
      start_i = 1'b0;
      wr_ready_i = 1'b0;
      check(busy_ok, "R12", "busy dropped before done", AW'(busy_ok), 1);
      check(nw == exp_n, "R3", "beat count", AW'(nw), AW'(exp_n));
      if (m == '0) check(waited == 1, "R4", "empty mask done cycle", AW'(waited), 1);
      if (pd) begin
         check(wb_valid_o == 1'b1, "R9", "writeback valid", AW'(wb_valid_o), 1);
         check(wb_addr_o == exp_final, "R9", "writeback address", wb_addr_o, exp_final);
      end else begin
         check(wb_valid_o == 1'b0, "R9", "writeback valid in ascending", AW'(wb_valid_o), 0);
      end
      @(negedge clk);
      #1;
      check(!done_o && !busy_o, "R12", "done not a single pulse",
            AW'({done_o, busy_o}), 0);
   endtask

   initial begin
      void'($urandom(32'd5150));
      load_regs();
      repeat (3) @(negedge clk);
      #1;
      check(!busy_o && !done_o && !wr_req_o && !wb_valid_o, "R12", "reset state",
            AW'({busy_o, done_o, wr_req_o, wb_valid_o}), 0);
      rst_n = 1'b1;

      // Directed corners.
      run_op(16'h0000, 1'b0, 1'b0, 32'h0000_1000, 0, 1'b0);
      run_op(16'h0000, 1'b1, 1'b1, 32'h0000_2000, 0, 1'b0);
      run_op(16'h0001, 1'b0, 1'b1, 32'h0000_3000, 0, 1'b0);
      run_op(16'h8000, 1'b1, 1'b1, 32'h0000_4000, 0, 1'b0);
      run_op(16'h0001, 1'b1, 1'b0, 32'h0000_5000, 0, 1'b0);
      run_op(16'hFFFF, 1'b0, 1'b1, 32'h0000_6000, 1, 1'b0);
      run_op(16'hFFFF, 1'b1, 1'b1, 32'h0000_7000, 1, 1'b0);
      run_op(16'h8001, 1'b1, 1'b0, 32'h0000_0004, 0, 1'b0);
      run_op(16'h4002, 1'b0, 1'b0, 32'hFFFF_FFFC, 1, 1'b0);
      // Spurious start mid-run (R12).
      run_op(16'h0F0F, 1'b1, 1'b1, 32'h0000_8000, 1, 1'b1);
      run_op(16'h00F0, 1'b0, 1'b0, 32'h0000_9000, 0, 1'b1);

      // Constrained random.
      for (int t = 0; t < 60; t++) begin
         logic [NREG-1:0] m;
         load_regs();
         m = $urandom;
         if (t % 4 == 0) m = m & $urandom & $urandom;
         run_op(m, $urandom_range(0, 1), $urandom_range(0, 1),
                {$urandom_range(0, 32'hFFFF), 1'b0} << 4, $urandom_range(0, 1), 1'b0);
      end
      summary();
   end
endmodule